// File: doc/BRIEF.md
# Serial EEPROM Target Emulator

This block is a synthesizable SPI target (mode 0) that answers like a small byte-addressed serial EEPROM. It is meant as a stand-in memory on a chip or as a known-good target for exercising an SPI host. The SPI pins are brought into the system clock domain and the serial clock is oversampled. The system clock therefore has to run several times faster than the serial clock.

A host first sets a write-enable latch. It then sends a program command with an address and up to one page of data. Those bytes collect in a page buffer. They reach the array only when chip select is released on a whole-byte boundary. After that the part reports busy for a fixed number of system cycles, accepts only status reads, and drops the write-enable latch when the busy time ends. Reads stream bytes for as long as chip select stays low, and the address wraps at the top of the array. A status write sets two block-protect bits and a protect-enable bit. The protect bits mask off the top quarter, the top half or the whole array against programming.

Top module: `spi_eeprom_emu`

## Requirements
- R1: After reset the status byte reads 0x00, and every array byte reads 0xFF.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Opcode 0x05 returns the status byte, MSB first, and repeats it for every further byte while chip select stays low. The status layout is: bit 0 busy, bit 1 write-enable latch, bit 2 protect bit P0, bit 3 protect bit P1, bit 7 protect-enable, and all other bits zero.
- R3: Opcode 0x03 takes ADDR_BYTES address bytes, most significant byte first, and returns consecutive bytes while chip select stays low. After the last array byte the address wraps to 0.
- R4: Opcode 0x02 takes an address followed by data bytes. Each data byte goes to the next address within the same PAGE_BYTES page, wrapping from the end of the page back to its start.
- R5: With NINE_BIT_ADDR set, bit 3 of the read or program opcode (0x0B or 0x0A) supplies address bit 8.
- R6: A program command or status write (0x01) issued while the write-enable latch is clear has no effect on the array or the status.
- R7: Buffered program data reaches the array only if chip select rises after a whole number of bytes. Otherwise nothing is written, busy stays clear and the write-enable latch stays set.
- R8: A commit holds the busy bit for BUSY_CYCLES cycles. Busy and the write-enable latch clear together. While busy, every opcode except 0x05 is ignored.
- R9: A status write changes only bits 2, 3 and 7. Protect value 01 blocks programming of the top quarter of the array, 10 the top half, and 11 all of it. Blocked bytes keep their old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data from the host, sampled on the rising edge |
| spi_miso | output | 1 | Serial data to the host, updated on the falling edge, low when deselected |

## Verification
Two things can happen in the same cycle: the busy timer expires, and the status shifter reloads at the end of a byte. The bench provokes this by keeping chip select low during a commit and streaming status bytes across the whole busy window. Every streamed byte must read either 0x03 or 0x00, and once 0x00 has appeared, 0x03 must not return. A byte that shows only one of the busy and write-enable bits would mean they are cleared in different cycles. A status write sent in the middle of that window must leave the protect bits unchanged.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR,
    ST_RDATA,
    ST_WDATA,
    ST_STAT,
    ST_SRDATA,
    ST_SKIP
  } ee_state_e;

  // top2 = two most significant address bits
  function automatic logic in_protected(input logic [1:0] top2, input logic [1:0] sel);
    case (sel)
      2'b01:   return top2 == 2'b11;
      2'b10:   return top2[1];
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/spi_eeprom_sync.sv
module spi_eeprom_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic cs_rise,
  output logic mosi_s
);

  logic [2:0] sck_q;
  logic [2:0] cs_q;
  logic [1:0] mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 3'b000;
      cs_q   <= 3'b111;
      mosi_q <= 2'b00;
    end else begin
      sck_q  <= {sck_q[1:0], sck};
      cs_q   <= {cs_q[1:0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  assign sck_rise = sck_q[1] & ~sck_q[2];
  assign sck_fall = ~sck_q[1] & sck_q[2];
  assign cs_act   = ~cs_q[1];
  assign cs_rise  = cs_q[1] & ~cs_q[2];
  assign mosi_s   = mosi_q[1];

endmodule

// File: rtl/spi_eeprom_busy.sv
module spi_eeprom_busy #(
  parameter int CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          busy_q, busy_n;

  assign done = busy_q && (cnt_q == '0);

  always_comb begin
    cnt_n  = cnt_q;
    busy_n = busy_q;
    if (start) begin
      busy_n = 1'b1;
      cnt_n  = CW'(CYCLES - 1);
    end else if (done) begin
      busy_n = 1'b0;
    end else if (busy_q) begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/spi_eeprom_array.sv
module spi_eeprom_array
  import spi_eeprom_pkg::*;
#(
  parameter int MEM_BYTES  = 512,
  parameter int PAGE_BYTES = 16
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic [$clog2(MEM_BYTES)-1:0]                rd_addr,
  output logic [7:0]                                  rd_data,
  input  logic                                        buf_clr,
  input  logic                                        buf_we,
  input  logic [$clog2(PAGE_BYTES)-1:0]               buf_idx,
  input  logic [7:0]                                  buf_data,
  input  logic [$clog2(MEM_BYTES)-$clog2(PAGE_BYTES)-1:0] page_base,
  input  logic                                        commit,
  input  logic [1:0]                                  prot_sel
);

  localparam int AW = $clog2(MEM_BYTES);
  localparam int PB = $clog2(PAGE_BYTES);

  logic [7:0]            mem_q  [MEM_BYTES];
  logic [7:0]            pbuf_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pval_q;
  logic [MEM_BYTES-1:0]  wr_hit;

  for (genvar g = 0; g < MEM_BYTES; g++) begin : g_hit
    localparam logic [AW-1:0] GA = AW'(g);
    assign wr_hit[g] = commit && (GA[AW-1:PB] == page_base) && pval_q[GA[PB-1:0]]
                       && !in_protected(GA[AW-1:AW-2], prot_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < MEM_BYTES; j++) mem_q[j] <= 8'hFF;
    end else begin
      for (int j = 0; j < MEM_BYTES; j++) begin
        if (wr_hit[j]) mem_q[j] <= pbuf_q[j % PAGE_BYTES];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf_q[buf_idx] <= buf_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pval_q <= '0;
    else if (buf_clr) pval_q <= '0;
    else if (buf_we)  pval_q[buf_idx] <= 1'b1;
  end

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/spi_eeprom_emu.sv
module spi_eeprom_emu
  import spi_eeprom_pkg::*;
#(
  parameter int MEM_BYTES     = 512,
  parameter int PAGE_BYTES    = 16,
  parameter int ADDR_BYTES    = 1,
  parameter int NINE_BIT_ADDR = 1,
  parameter int BUSY_CYCLES   = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic spi_miso
);

  localparam int AW  = $clog2(MEM_BYTES);
  localparam int PB  = $clog2(PAGE_BYTES);
  localparam int ACW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [7:0] OP_MASK = (NINE_BIT_ADDR != 0) ? 8'hF7 : 8'hFF;

  logic sck_rise, sck_fall, cs_act, cs_rise, mosi_s;
  logic busy, busy_done, commit, sr_go;

  ee_state_e         st_q, st_n;
  logic [2:0]        bit_q, bit_n;
  logic [7:0]        rx_q, rx_n, tx_q, tx_n, op_q, op_n, srv_q, srv_n;
  logic [AW-1:0]     addr_q, addr_n, addr_new, rd_addr;
  logic [ACW-1:0]    acnt_q, acnt_n;
  logic [PB-1:0]     widx_q, widx_n;
  logic [AW-PB-1:0]  page_q, page_n;
  logic              wel_q, wel_n, wpen_q, wpen_n, wpend_q, wpend_n, spend_q, spend_n;
  logic [1:0]        bp_q, bp_n;
  logic              buf_clr, buf_we;
  logic [7:0]        rd_data, rx_byte, status, op_base;

  spi_eeprom_sync u_sync (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act), .cs_rise(cs_rise),
    .mosi_s(mosi_s)
  );

  spi_eeprom_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(commit | sr_go), .busy(busy), .done(busy_done)
  );

  spi_eeprom_array #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .buf_clr(buf_clr), .buf_we(buf_we), .buf_idx(widx_q), .buf_data(rx_byte),
    .page_base(page_q), .commit(commit), .prot_sel(bp_q)
  );

  assign rx_byte  = {rx_q[6:0], mosi_s};
  assign status   = {wpen_q, 3'b000, bp_q, wel_q, busy};
  assign op_base  = op_q & OP_MASK;
  assign addr_new = (NINE_BIT_ADDR != 0) ? AW'({op_q[3], rx_byte}) : AW'({addr_q, rx_byte});
  assign rd_addr  = (st_q == ST_ADDR) ? addr_new : addr_q;
  assign commit   = cs_rise && (bit_q == 3'd0) && wpend_q;
  assign sr_go    = cs_rise && (bit_q == 3'd0) && spend_q;

  always_comb begin
    st_n = st_q;    bit_n = bit_q;   rx_n = rx_q;     tx_n = tx_q;
    op_n = op_q;    srv_n = srv_q;   addr_n = addr_q; acnt_n = acnt_q;
    widx_n = widx_q; page_n = page_q; wel_n = wel_q;  wpen_n = wpen_q;
    bp_n = bp_q;    wpend_n = wpend_q; spend_n = spend_q;
    buf_clr = 1'b0; buf_we = 1'b0;

    if (busy_done) wel_n = 1'b0;
    if (sr_go) begin
      bp_n   = srv_q[3:2];
      wpen_n = srv_q[7];
    end

    if (!cs_act) begin
      st_n = ST_CMD; bit_n = 3'd0; tx_n = 8'h00; wpend_n = 1'b0; spend_n = 1'b0;
    end else if (sck_rise) begin
      bit_n = bit_q + 3'd1;
      rx_n  = rx_byte;
      if (bit_q == 3'd7) begin
        unique case (st_q)
          ST_CMD: begin
            op_n   = rx_byte;
            acnt_n = '0;
            st_n   = ST_SKIP;
            if (rx_byte == OP_RDSR) begin
              st_n = ST_STAT;
              tx_n = status;
            end else if (!busy) begin
              if (rx_byte == OP_WREN) wel_n = 1'b1;
              else if (rx_byte == OP_WRDI) wel_n = 1'b0;
              else if (rx_byte == OP_WRSR && wel_q) st_n = ST_SRDATA;
              else if ((rx_byte & OP_MASK) == OP_READ) st_n = ST_ADDR;
              else if ((rx_byte & OP_MASK) == OP_PROG && wel_q) begin
                st_n    = ST_ADDR;
                buf_clr = 1'b1;
              end
            end
          end
          ST_ADDR: begin
            acnt_n = acnt_q + 1'b1;
            addr_n = addr_new;
            if (acnt_q == ACW'(ADDR_BYTES - 1)) begin
              if (op_base == OP_READ) begin
                tx_n   = rd_data;
                addr_n = addr_new + 1'b1;
                st_n   = ST_RDATA;
              end else begin
                page_n = addr_new[AW-1:PB];
                widx_n = addr_new[PB-1:0];
                st_n   = ST_WDATA;
              end
            end
          end
          ST_RDATA: begin
            tx_n   = rd_data;
            addr_n = addr_q + 1'b1;
          end
          ST_WDATA: begin
            buf_we  = 1'b1;
            widx_n  = widx_q + 1'b1;
            wpend_n = 1'b1;
          end
          ST_STAT: tx_n = status;
          ST_SRDATA: begin
            srv_n   = rx_byte;
            spend_n = 1'b1;
            st_n    = ST_SKIP;
          end
          default: ;
        endcase
      end
    end else if (sck_fall && bit_q != 3'd0) begin
      tx_n = {tx_q[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_CMD;  bit_q <= '0;  rx_q <= '0;   tx_q <= '0;
      op_q <= '0;      srv_q <= '0;  addr_q <= '0; acnt_q <= '0;
      widx_q <= '0;    page_q <= '0; wel_q <= 1'b0; wpen_q <= 1'b0;
      bp_q <= '0;      wpend_q <= 1'b0; spend_q <= 1'b0;
    end else begin
      st_q <= st_n;    bit_q <= bit_n; rx_q <= rx_n;   tx_q <= tx_n;
      op_q <= op_n;    srv_q <= srv_n; addr_q <= addr_n; acnt_q <= acnt_n;
      widx_q <= widx_n; page_q <= page_n; wel_q <= wel_n; wpen_q <= wpen_n;
      bp_q <= bp_n;    wpend_q <= wpend_n; spend_q <= spend_n;
    end
  end

  assign spi_miso = cs_act & tx_q[7];

endmodule

// File: rtl/spi_eeprom_emu_chk.sv
module spi_eeprom_emu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       wel,
  input logic [1:0] bp,
  input logic       cs_rise
);

  // R8: the busy timer only runs while the latch is set
  a_r8_busy_has_wel: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> wel);

  // R8: latch and busy fall in the same cycle
  a_r8_fall_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  // R6: a busy period starts only with the latch set
  a_r6_start_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));

  // R7: busy starts only on a chip select release
  a_r7_commit_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise));

  // R8 / R9: protect bits frozen while busy
  a_r9_bp_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(bp));

  // R2: the latch cannot be set during busy
  a_r2_wel_rise_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !$past(busy));

endmodule

bind spi_eeprom_emu spi_eeprom_emu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wel(wel_q), .bp(bp_q), .cs_rise(cs_rise)
);

// File: tb/spi_eeprom_emu_bench.sv
`timescale 1ns/1ps
module spi_eeprom_emu_bench;

  localparam int HALF = 6;
  localparam int NVEC = 9;
  // {is_write, addr[8:0], wdata, expected}
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b1, 9'h000, 8'h11, 8'h00},
    {1'b1, 9'h0A5, 8'h5A, 8'h00},
    {1'b1, 9'h1FF, 8'hEE, 8'h00},
    {1'b1, 9'h105, 8'h77, 8'h00},
    {1'b0, 9'h000, 8'h00, 8'h11},
    {1'b0, 9'h0A5, 8'h00, 8'h5A},
    {1'b0, 9'h1FF, 8'h00, 8'hEE},
    {1'b0, 9'h105, 8'h00, 8'h77},
    {1'b0, 9'h005, 8'h00, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso;
  int   n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] v, s;

  always #4 clk = ~clk;

  spi_eeprom_emu #(.BUSY_CYCLES(600)) u_spi_eeprom_emu (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
    .spi_mosi(mosi), .spi_miso(miso)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung run, expected completion");
      finish_run();
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_lo();
    cs_n = 1'b0; tick(HALF);
  endtask

  task automatic cs_hi();
    tick(HALF); cs_n = 1'b1; tick(2 * HALF);
  endtask

  task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      tick(HALF);
      rx[i] = miso;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xbits(tx, 8, rx);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    cs_lo(); xfer(op, d); cs_hi();
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] d;
    cs_lo(); xfer(8'h05, d); xfer(8'h00, st); cs_hi();
  endtask

  task automatic wait_ready();
    logic [7:0] st;
    for (int k = 0; k < 40; k++) begin
      rdsr(st);
      if (!st[0]) break;
    end
  endtask

  task automatic prog_start(input logic [8:0] a);
    logic [7:0] d;
    cs_lo(); xfer(8'h02 | {4'b0, a[8], 3'b0}, d); xfer(a[7:0], d);
  endtask

  task automatic write1(input logic [8:0] a, input logic [7:0] val);
    logic [7:0] d;
    cmd1(8'h06); prog_start(a); xfer(val, d); cs_hi(); wait_ready();
  endtask

  task automatic read1(input logic [8:0] a, output logic [7:0] val);
    logic [7:0] d;
    cs_lo(); xfer(8'h03 | {4'b0, a[8], 3'b0}, d); xfer(a[7:0], d); xfer(8'h00, val); cs_hi();
  endtask

  task automatic wrsr(input logic [7:0] val);
    logic [7:0] d;
    cmd1(8'h06); cs_lo(); xfer(8'h01, d); xfer(val, d); cs_hi(); wait_ready();
  endtask

  initial begin
    logic [7:0] d, b1, b2, b3;
    logic seen_idle, bad;
    tick(5); rst_n = 1'b1; tick(5);

    // R1 reset state
    rdsr(s);          check("R1 status after reset", s, 8'h00);
    read1(9'h033, v); check("R1 erased array", v, 8'hFF);

    // table: R3 / R4 / R5 single byte write then read
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][25]) write1(VEC[i][24:16], VEC[i][15:8]);
      else begin
        read1(VEC[i][24:16], v);
        check($sformatf("R3 R5 vector %0d", i), v, VEC[i][7:0]);
      end
    end

    // R2 latch set and clear
    cmd1(8'h06); rdsr(s); check("R2 WREN sets latch", s, 8'h02);
    cmd1(8'h04); rdsr(s); check("R2 WRDI clears latch", s, 8'h00);

    // R6 program and status write without latch
    prog_start(9'h040); xfer(8'h55, d); cs_hi();
    read1(9'h040, v); check("R6 program without latch", v, 8'hFF);
    cs_lo(); xfer(8'h01, d); xfer(8'h8C, d); cs_hi();
    rdsr(s); check("R6 status write without latch", s, 8'h00);

    // R4 page wrap
    cmd1(8'h06); prog_start(9'h01E);
    xfer(8'hAA, d); xfer(8'hBB, d); xfer(8'hCC, d); xfer(8'hDD, d);
    cs_hi(); wait_ready();
    read1(9'h010, v); check("R4 wrap first", v, 8'hCC);
    read1(9'h011, v); check("R4 wrap second", v, 8'hDD);
    read1(9'h01E, v); check("R4 page start", v, 8'hAA);
    read1(9'h01F, v); check("R4 page end", v, 8'hBB);
    read1(9'h020, v); check("R4 next page untouched", v, 8'hFF);

    // R3 sequential read with array wrap
    cs_lo(); xfer(8'h0B, d); xfer(8'hFF, d);
    xfer(8'h00, b1); xfer(8'h00, b2); xfer(8'h00, b3); cs_hi();
    check("R3 last byte", b1, 8'hEE);
    check("R3 wrap to 0", b2, 8'h11);
    check("R3 address 1", b3, 8'hFF);

    // R7 release off a byte boundary
    cmd1(8'h06); prog_start(9'h060); xfer(8'h99, d); xbits(8'h00, 3, d); cs_hi();
    rdsr(s); check("R7 no commit, latch kept", s, 8'h02);
    read1(9'h060, v); check("R7 array unchanged", v, 8'hFF);
    cmd1(8'h04);

    // R8 busy window, overlap of timer expiry and status reload
    cmd1(8'h06); prog_start(9'h070); xfer(8'h42, d); cs_hi();
    rdsr(s); check("R8 busy after commit", s, 8'h03);
    cs_lo(); xfer(8'h01, d); xfer(8'h0C, d); cs_hi();
    cs_lo(); xfer(8'h05, d);
    seen_idle = 1'b0; bad = 1'b0;
    for (int k = 0; k < 12; k++) begin
      xfer(8'h00, s);
      if (s == 8'h00) seen_idle = 1'b1;
      else if (s != 8'h03 || seen_idle) bad = 1'b1;
    end
    cs_hi();
    check("R8 streamed status legal", {7'b0, bad}, 8'h00);
    check("R8 stream ends idle", s, 8'h00);
    rdsr(s); check("R8 status write during busy ignored", s, 8'h00);
    read1(9'h070, v); check("R8 committed byte", v, 8'h42);

    // R9 status write and protection
    wrsr(8'h87); rdsr(s); check("R9 only bits 7,3,2", s, 8'h84);
    write1(9'h190, 8'h31); read1(9'h190, v); check("R9 top quarter blocked", v, 8'hFF);
    write1(9'h010, 8'h32); read1(9'h010, v); check("R9 low area open", v, 8'h32);
    wrsr(8'h08);
    write1(9'h100, 8'h21); read1(9'h100, v); check("R9 top half blocked", v, 8'hFF);
    write1(9'h0FF, 8'h22); read1(9'h0FF, v); check("R9 lower half open", v, 8'h22);
    wrsr(8'h0C);
    write1(9'h000, 8'h23); read1(9'h000, v); check("R9 all blocked", v, 8'h11);
    wrsr(8'h00); rdsr(s); check("R9 protection cleared", s, 8'h00);

    finish_run();
  end

endmodule